// File: doc/BRIEF.md
# Speculative Reservation Translation Predictor

This block sits beside a TLB and predicts physical page numbers for TLB misses from a small table of 2MB reservation regions. When a miss lookup names a virtual page, every valid entry compares its region tag (the virtual page number with its low 9 bits dropped). If one entry matches, the predicted physical page is that entry's 2MB-aligned physical base joined with the low 9 bits of the missing page. The pipeline can then run ahead while the real page walk proceeds. With no match, no prediction is made.

Entries are created from completed walks on the fill port. A fill is installed only when the low 9 bits of its virtual and physical page numbers are equal, meaning the page sits at the same offset in both 2MB regions. When the walk finishes, the verify port compares the prediction with the walked page. A confirmed prediction pulses `confirmOk`, which is also the signal that lets a speculative store commit. A refuted one pulses `mispredict` and drops the region. A flush, raised on an address-space switch, empties the table in one cycle. Victims are taken from empty slots first, and otherwise from a pseudo-random source.

Top module: `spec_resv_predictor`

## Requirements
- R1: After reset the table is empty: `predValid` is 0 and a lookup of any page gives no prediction.
- R2: A lookup whose 2MB region is not held by any valid entry gives `predValid` = 0 in the cycle after the lookup.
- R3: After an installed fill of virtual page V and physical page P, a lookup of any page W in V's region gives `predValid` = 1 in the next cycle, with `predPpn` = {P[PPN_W-1:9], W[8:0]}.
- R4: A fill whose VPN bits [8:0] differ from its PPN bits [8:0] is ignored and installs nothing.
- R5: A fill for a region that is already present overwrites that entry's physical base and does not take a second slot.
- R6: A verify with predicted PPN equal to the walked PPN pulses `confirmOk` in the same cycle and keeps the entry. A verify with unequal values pulses `mispredict` in the same cycle, invalidates the entry holding the verified region at that clock edge, and leaves other regions untouched.
- R7: A flush clears every entry at the next clock edge, so later lookups give no prediction until new fills arrive.
- R8: While empty slots remain, a fill of a new region takes an empty slot, so NUM_ENTRIES distinct regions can all be held at once.
- R9: When the table is full, a fill of a new region evicts exactly one existing region, and the new region is predicted afterwards.
- R10: A lookup reads the table as it stood before the clock edge, so a fill in the same cycle as a lookup of its region gives no prediction for that lookup.
- R11: A flush takes priority over a fill in the same cycle; that fill is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all entries (address-space switch) |
| lookupValid | input | 1 | TLB miss lookup strobe |
| lookupVpn | input | VPN_W | Missing virtual page number |
| predValid | output | 1 | Prediction available (one cycle after lookup) |
| predPpn | output | PPN_W | Predicted physical page number |
| fillValid | input | 1 | Completed page walk strobe |
| fillVpn | input | VPN_W | Walked virtual page number |
| fillPpn | input | PPN_W | Walked physical page number |
| verifyValid | input | 1 | Verification of an earlier prediction |
| verifyVpn | input | VPN_W | Virtual page that was predicted |
| verifyPredPpn | input | PPN_W | Page number that was predicted |
| verifyWalkPpn | input | PPN_W | Page number returned by the walk |
| mispredict | output | 1 | Prediction refuted (combinational pulse) |
| confirmOk | output | 1 | Prediction confirmed; speculative store may commit |

## Verification
The bench updates one region twice and then fills the rest of the table. A design that allocated a duplicate would leave a stale base in another slot or lose one region to eviction, and the hit count would fall short of the table size. It overfills the table by one region and requires exactly NUM_ENTRIES hits. A victim picker that skipped empty slots, or evicted more than one entry, would miss that count. It also drives a fill in the same cycle as a lookup of that region, and a flush in the same cycle as a fill. A design that bypassed the write path or let the fill override the flush would predict where it must not. Misaligned fills and mispredict verifies are followed by lookups of the affected region, which catches a design that installed or kept an entry it should have dropped.

// File: rtl/spr_pkg.sv
package spr_pkg;
  // Strobes from control to the table datapath
  typedef struct packed {
    logic wrEn;      // write fill into wrIdx
    logic invEn;     // invalidate invIdx
    logic flushAll;  // clear every valid bit
  } ctlStrobes_t;

  localparam int OFF_W = 9;  // 512 small pages per 2MB region
endpackage

// File: rtl/spr_table.sv
module spr_table
  import spr_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int VPN_W = 36,
  parameter int PPN_W = 28,
  localparam int TAG_W = VPN_W - OFF_W,
  localparam int BASE_W = PPN_W - OFF_W,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobes_t            strobes,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [IDX_W-1:0]       invIdx,
  input  logic [TAG_W-1:0]       wrTag,
  input  logic [BASE_W-1:0]      wrBase,
  input  logic [TAG_W-1:0]       lkTag,
  input  logic [TAG_W-1:0]       fillTag,
  input  logic [TAG_W-1:0]       verTag,
  output logic                   lkHit,
  output logic [BASE_W-1:0]      lkBase,
  output logic [NUM_ENTRIES-1:0] fillHitVec,
  output logic [NUM_ENTRIES-1:0] verHitVec,
  output logic [NUM_ENTRIES-1:0] validVec
);
  logic [TAG_W-1:0]       tagMem  [NUM_ENTRIES];
  logic [BASE_W-1:0]      baseMem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] lkHitVec;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    assign lkHitVec[i]   = validVec[i] && (tagMem[i] == lkTag);
    assign fillHitVec[i] = validVec[i] && (tagMem[i] == fillTag);
    assign verHitVec[i]  = validVec[i] && (tagMem[i] == verTag);

    always_ff @(posedge clk) begin
      if (!rstN || strobes.flushAll) begin
        validVec[i] <= 1'b0;
      end else if (strobes.wrEn && wrIdx == IDX_W'(i)) begin
        validVec[i] <= 1'b1;
      end else if (strobes.invEn && invIdx == IDX_W'(i)) begin
        validVec[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobes.wrEn && !strobes.flushAll && wrIdx == IDX_W'(i)) begin
        tagMem[i]  <= wrTag;
        baseMem[i] <= wrBase;
      end
    end
  end

  // At most one entry matches a region, so an OR-reduce selects its base
  always_comb begin
    lkHit  = |lkHitVec;
    lkBase = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lkHitVec[i]) lkBase = lkBase | baseMem[i];
    end
  end
endmodule

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import spr_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int VPN_W = 36,
  parameter int PPN_W = 28,
  localparam int BASE_W = PPN_W - OFF_W,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  logic                   lookupValid,
  input  logic [OFF_W-1:0]       lookupOff,
  input  logic                   fillValid,
  input  logic [OFF_W-1:0]       fillVpnOff,
  input  logic [OFF_W-1:0]       fillPpnOff,
  input  logic                   verifyValid,
  input  logic [PPN_W-1:0]       verifyPredPpn,
  input  logic [PPN_W-1:0]       verifyWalkPpn,
  input  logic                   lkHit,
  input  logic [BASE_W-1:0]      lkBase,
  input  logic [NUM_ENTRIES-1:0] fillHitVec,
  input  logic [NUM_ENTRIES-1:0] verHitVec,
  input  logic [NUM_ENTRIES-1:0] validVec,
  output ctlStrobes_t            strobes,
  output logic [IDX_W-1:0]       wrIdx,
  output logic [IDX_W-1:0]       invIdx,
  output logic                   predValid,
  output logic [PPN_W-1:0]       predPpn,
  output logic                   mispredict,
  output logic                   confirmOk
);
  logic [7:0]       lfsr;
  logic [7:0]       lfsrMod;
  logic [IDX_W-1:0] freeIdx, fillIdx, victimIdx;
  logic             anyFree, fillHit, verHit, aligned;

  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= 8'hA5;
    else       lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  // Lowest-index encoders: scan downwards so the smallest index wins
  always_comb begin
    freeIdx = '0;
    fillIdx = '0;
    invIdx  = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i])  freeIdx = IDX_W'(i);
      if (fillHitVec[i]) fillIdx = IDX_W'(i);
      if (verHitVec[i])  invIdx  = IDX_W'(i);
    end
  end

  assign anyFree   = ~&validVec;
  assign fillHit   = |fillHitVec;
  assign verHit    = |verHitVec;
  assign lfsrMod   = lfsr % 8'(NUM_ENTRIES);
  assign victimIdx = anyFree ? freeIdx : lfsrMod[IDX_W-1:0];
  assign aligned   = (fillVpnOff == fillPpnOff);
  assign wrIdx     = fillHit ? fillIdx : victimIdx;

  assign mispredict = verifyValid && (verifyPredPpn != verifyWalkPpn);
  assign confirmOk  = verifyValid && (verifyPredPpn == verifyWalkPpn);

  always_comb begin
    strobes.flushAll = flush;
    strobes.wrEn     = fillValid && aligned && !flush;
    strobes.invEn    = mispredict && verHit && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid <= 1'b0;
      predPpn   <= '0;
    end else begin
      predValid <= lookupValid && lkHit;
      predPpn   <= {lkBase, lookupOff};
    end
  end
endmodule

// File: rtl/spec_resv_predictor.sv
module spec_resv_predictor
  import spr_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int VPN_W = 36,
  parameter int PPN_W = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             predValid,
  output logic [PPN_W-1:0] predPpn,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             verifyValid,
  input  logic [VPN_W-1:0] verifyVpn,
  input  logic [PPN_W-1:0] verifyPredPpn,
  input  logic [PPN_W-1:0] verifyWalkPpn,
  output logic             mispredict,
  output logic             confirmOk
);
  localparam int TAG_W  = VPN_W - OFF_W;
  localparam int BASE_W = PPN_W - OFF_W;
  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  ctlStrobes_t            strobes;
  logic [IDX_W-1:0]       wrIdx, invIdx;
  logic                   lkHit;
  logic [BASE_W-1:0]      lkBase;
  logic [NUM_ENTRIES-1:0] fillHitVec, verHitVec, validVec;

  spr_table #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_table (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrIdx      (wrIdx),
    .invIdx     (invIdx),
    .wrTag      (fillVpn[VPN_W-1:OFF_W]),
    .wrBase     (fillPpn[PPN_W-1:OFF_W]),
    .lkTag      (lookupVpn[VPN_W-1:OFF_W]),
    .fillTag    (fillVpn[VPN_W-1:OFF_W]),
    .verTag     (verifyVpn[VPN_W-1:OFF_W]),
    .lkHit      (lkHit),
    .lkBase     (lkBase),
    .fillHitVec (fillHitVec),
    .verHitVec  (verHitVec),
    .validVec   (validVec)
  );

  spr_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .flush         (flush),
    .lookupValid   (lookupValid),
    .lookupOff     (lookupVpn[OFF_W-1:0]),
    .fillValid     (fillValid),
    .fillVpnOff    (fillVpn[OFF_W-1:0]),
    .fillPpnOff    (fillPpn[OFF_W-1:0]),
    .verifyValid   (verifyValid),
    .verifyPredPpn (verifyPredPpn),
    .verifyWalkPpn (verifyWalkPpn),
    .lkHit         (lkHit),
    .lkBase        (lkBase),
    .fillHitVec    (fillHitVec),
    .verHitVec     (verHitVec),
    .validVec      (validVec),
    .strobes       (strobes),
    .wrIdx         (wrIdx),
    .invIdx        (invIdx),
    .predValid     (predValid),
    .predPpn       (predPpn),
    .mispredict    (mispredict),
    .confirmOk     (confirmOk)
  );
endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
  parameter int NUM_ENTRIES = 24,
  parameter int VPN_W = 36,
  parameter int PPN_W = 28
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   flush,
  input logic                   lookupValid,
  input logic [VPN_W-1:0]       lookupVpn,
  input logic                   predValid,
  input logic [PPN_W-1:0]       predPpn,
  input logic                   mispredict,
  input logic                   confirmOk,
  input logic [NUM_ENTRIES-1:0] validVec
);
  // R2
  pred_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> $past(lookupValid));

  // R3
  pred_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> predPpn[8:0] == $past(lookupVpn[8:0]));

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validVec == '0));

  // R6
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mispredict && confirmOk));

  // R7
  no_pred_after_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) |=> !predValid);
endmodule

bind spec_resv_predictor spr_checker #(
  .NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .flush       (flush),
  .lookupValid (lookupValid),
  .lookupVpn   (lookupVpn),
  .predValid   (predValid),
  .predPpn     (predPpn),
  .mispredict  (mispredict),
  .confirmOk   (confirmOk),
  .validVec    (validVec)
);

// File: tb/sim_spec_resv_predictor.sv
module sim_spec_resv_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam int VPN_W = 36;
  localparam int PPN_W = 28;

  logic clk = 0, rstN = 0, flush = 0;
  logic lookupValid = 0, fillValid = 0, verifyValid = 0;
  logic [VPN_W-1:0] lookupVpn = '0, fillVpn = '0, verifyVpn = '0;
  logic [PPN_W-1:0] fillPpn = '0, verifyPredPpn = '0, verifyWalkPpn = '0;
  logic predValid, mispredict, confirmOk;
  logic [PPN_W-1:0] predPpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_resv_predictor #(.NUM_ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u0 (.*);

  typedef struct {
    bit dc; bit v; logic [PPN_W-1:0] ppn; string req;
  } expItem_t;
  expItem_t expQ[$];
  int checks = 0, fails = 0, hitCount = 0;
  bit lkSeen = 0;

  function automatic logic [VPN_W-1:0] va(int region, int off);
    return (VPN_W'(region) << 9) | VPN_W'(off);
  endfunction
  function automatic logic [PPN_W-1:0] pa(int base, int off);
    return (PPN_W'(base) << 9) | PPN_W'(off);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drivers: called at a falling edge, return at the next falling edge
  task automatic doLookup(logic [VPN_W-1:0] v, bit expV, logic [PPN_W-1:0] expP,
                          string req, bit dc = 0);
    expItem_t it;
    it.dc = dc; it.v = expV; it.ppn = expP; it.req = req;
    expQ.push_back(it);
    lookupValid = 1; lookupVpn = v;
    @(negedge clk);
    lookupValid = 0;
  endtask

  task automatic doFill(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p);
    fillValid = 1; fillVpn = v; fillPpn = p;
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic doVerify(logic [VPN_W-1:0] v, logic [PPN_W-1:0] pr,
                          logic [PPN_W-1:0] wk, string req);
    verifyValid = 1; verifyVpn = v; verifyPredPpn = pr; verifyWalkPpn = wk;
    #1;
    check(mispredict == (pr != wk), req, "mispredict", longint'(mispredict), longint'(pr != wk));
    check(confirmOk == (pr == wk), req, "confirmOk", longint'(confirmOk), longint'(pr == wk));
    @(negedge clk);
    verifyValid = 0;
  endtask

  // Monitor: a lookup seen at a rising edge has its result valid by the next falling edge
  always @(posedge clk) lkSeen <= lookupValid;
  always @(negedge clk) begin
    if (lkSeen) begin
      expItem_t it;
      if (expQ.size() == 0) check(0, "R2", "unexpected result", 1, 0);
      else begin
        it = expQ.pop_front();
        if (it.dc) begin
          if (predValid) hitCount++;
        end else begin
          check(predValid == it.v, it.req, "predValid", longint'(predValid), longint'(it.v));
          if (it.v)
            check(predPpn == it.ppn, it.req, "predPpn", longint'(predPpn), longint'(it.ppn));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    check(predValid == 0, "R1", "predValid after reset", longint'(predValid), 0);
    doLookup(va(5, 3), 0, '0, "R1");
    // R2: unknown region
    doLookup(va(77, 0), 0, '0, "R2");
    // R3: aligned fill then lookups in region
    doFill(va(10, 17), pa(300, 17));
    doLookup(va(10, 17), 1, pa(300, 17), "R3");
    doLookup(va(10, 511), 1, pa(300, 511), "R3");
    doLookup(va(10, 0), 1, pa(300, 0), "R3");
    doLookup(va(11, 0), 0, '0, "R2");
    // R4: misaligned fill ignored
    doFill(va(12, 4), pa(400, 5));
    doLookup(va(12, 4), 0, '0, "R4");
    // R6: confirm keeps, mispredict drops only that region
    doFill(va(13, 2), pa(500, 2));
    doVerify(va(10, 9), pa(300, 9), pa(300, 9), "R6");
    doLookup(va(10, 9), 1, pa(300, 9), "R6");
    doVerify(va(10, 9), pa(300, 9), pa(301, 9), "R6");
    doLookup(va(10, 9), 0, '0, "R6");
    doLookup(va(13, 8), 1, pa(500, 8), "R6");
    // R7: flush clears
    flush = 1; @(negedge clk); flush = 0;
    doLookup(va(13, 8), 0, '0, "R7");
    // R10: lookup same cycle as fill sees old state
    fillValid = 1; fillVpn = va(20, 1); fillPpn = pa(600, 1);
    doLookup(va(20, 1), 0, '0, "R10");
    fillValid = 0;
    doLookup(va(20, 1), 1, pa(600, 1), "R10");
    // R11: flush beats fill
    flush = 1; fillValid = 1; fillVpn = va(21, 1); fillPpn = pa(601, 1);
    @(negedge clk);
    flush = 0; fillValid = 0;
    doLookup(va(21, 1), 0, '0, "R11");
    doLookup(va(20, 1), 0, '0, "R11");
    // R5 / R8: update in place, then fill the remaining slots
    doFill(va(100, 0), pa(200, 0));
    doFill(va(100, 3), pa(250, 3));
    for (int i = 1; i < N; i++) doFill(va(100 + i, 0), pa(200 + i, 0));
    doLookup(va(100, 6), 1, pa(250, 6), "R5");
    hitCount = 0;
    for (int i = 0; i < N; i++) doLookup(va(100 + i, 1), 0, '0, "R8", 1);
    @(negedge clk);
    check(hitCount == N, "R8", "hits with table exactly full", hitCount, N);
    // R9: overfill by one region
    doFill(va(900, 0), pa(950, 0));
    doLookup(va(900, 2), 1, pa(950, 2), "R9");
    hitCount = 0;
    for (int i = 0; i < N; i++) doLookup(va(100 + i, 1), 0, '0, "R9", 1);
    @(negedge clk);
    check(hitCount == N - 1, "R9", "old regions kept after eviction", hitCount, N - 1);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2", "pending results", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule